// File: doc/BRIEF.md
# Multi-Stage Reset Release Sequencer

This block gathers several active-high reset requests (power-on, brown-out, external pin, watchdog, software) into one internal reset output. The output rises in the same cycle as any raw request. The requests also pass through a two-flop synchronizer. After every synchronized request has dropped, a state machine runs a fixed three-stage release chain and only then lowers the reset.

The first stage waits a number of slow-tick pulses, chosen by a 2-bit setting. The slow tick is a one-cycle enable, already synchronous to the main clock, that stands in for a 1 kHz oscillator. The second stage is a fixed 6-cycle oscillator settle wait. The third stage is a fixed 24-cycle calibration load. In that stage the block reads three words from a simple non-volatile memory port and stores them in the calibration registers for the 2 MHz, 32 MHz and 32 kHz oscillators. A request that arrives at any point sends the machine back to its reset state. Once all requests are gone, the chain starts again from the beginning.

States and transitions:
- ST_RESET → ST_DELAY when no synchronized request is active.
- ST_DELAY → ST_OSC when the tick count reaches the latched target.
- ST_OSC → ST_CAL after the settle cycles.
- ST_CAL → ST_RUN after the load cycles.
- Any state → ST_RESET while a synchronized request is active.

Top module: `rst_release_seq`

## Requirements
- R1: `rst_o` is 1 in any cycle in which any bit of `req_i` is 1, with no clock edge needed. Otherwise it is 1 in every stage except RUN.
- R2: When a request is applied in any stage, including RUN, `stage_o` reads RESET (0) after the third rising edge. It stays RESET for as long as any request remains high.
- R3: `stage_o` uses these encodings: RESET=0, DELAY=1, OSC_START=2, CAL_LOAD=3, RUN=4. After all requests drop, the stage becomes DELAY at the third rising edge. The stages then follow only the order DELAY, OSC_START, CAL_LOAD, RUN.
- R4: `sut_sel_i` is latched on the edge that leaves RESET. The setting 2'b00 selects 64 ticks, 2'b01 selects 4 ticks, 2'b11 selects 0 ticks, and the reserved value 2'b10 selects 64 ticks.
- R5: In DELAY, each edge with `slow_tick_i`=1 adds one to the tick count. DELAY ends on the edge after the edge that carried the final tick. Ticks that arrive outside DELAY, including during RESET, are not counted.
- R6: With a 0-tick setting, DELAY lasts exactly one clock cycle and needs no tick.
- R7: OSC_START lasts exactly 6 clock cycles.
- R8: CAL_LOAD lasts exactly 24 cycles. `nvm_rd_o` is 1 only at cycle offsets 0, 8 and 16 of that stage, and `nvm_addr_o` is 0, 1 and 2 at those offsets. `nvm_data_i` is sampled on the edge that ends each read cycle.
- R9: In RUN, `cal_2m_o`, `cal_32m_o` and `cal_32k_o` hold the words read from addresses 0, 1 and 2 during the most recent load.
- R10: `run_pulse_o` is 1 only in the first RUN cycle, and `rst_o` is 0 in RUN.
- R11: After an abort, the next release repeats the whole delay count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's own flops |
| req_i | input | NUM_REQ | Active-high reset requests |
| slow_tick_i | input | 1 | One-cycle slow-tick enable |
| sut_sel_i | input | 2 | Delay length setting |
| nvm_data_i | input | CAL_W | Memory read data, valid in the read cycle |
| nvm_rd_o | output | 1 | Memory read strobe |
| nvm_addr_o | output | ADDR_W | Memory word address |
| cal_2m_o | output | CAL_W | Calibration word for the 2 MHz oscillator |
| cal_32m_o | output | CAL_W | Calibration word for the 32 MHz oscillator |
| cal_32k_o | output | CAL_W | Calibration word for the 32 kHz oscillator |
| rst_o | output | 1 | Internal reset output |
| stage_o | output | 3 | Current stage code |
| run_pulse_o | output | 1 | One-cycle pulse on entry to RUN |

## Verification
Responses arrive at different delays, and each check is placed to match:
- **Reset output:** `rst_o` reacts within the same cycle as a raw request, so it is checked one time unit after the input changes.
- **Stage after a request change:** the stage code moves three rising edges after a request changes, because of the two synchronizer flops and the state register.
- **Stage within the chain:** it moves one edge after the tick count or the cycle count reaches its limit.

The bench drives inputs at falling edges and samples at the next falling edge. It walks through the chain edge by edge, so every stage length and read offset is compared in the exact cycle it is due. Random delay settings, tick gaps, memory contents and abort points are mixed with directed runs of the reserved setting, the zero setting and ticks during reset.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
    typedef enum logic [2:0] {
        ST_RESET = 3'd0,
        ST_DELAY = 3'd1,
        ST_OSC   = 3'd2,
        ST_CAL   = 3'd3,
        ST_RUN   = 3'd4
    } rsq_stage_e;
endpackage

// File: rtl/rsq_sync2.sv
module rsq_sync2 #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/rsq_dly_map.sv
module rsq_dly_map #(
    parameter int DLY_LONG  = 64,
    parameter int DLY_SHORT = 4,
    parameter int DLY_W     = $clog2(DLY_LONG + 1)
) (
    input  logic [1:0]       sel_i,
    output logic [DLY_W-1:0] ticks_o
);
    always_comb begin
        unique case (sel_i)
            2'b00:   ticks_o = DLY_W'(DLY_LONG);
            2'b01:   ticks_o = DLY_W'(DLY_SHORT);
            2'b10:   ticks_o = DLY_W'(DLY_LONG);   // reserved code falls back to long
            2'b11:   ticks_o = '0;
            default: ticks_o = DLY_W'(DLY_LONG);
        endcase
    end
endmodule

// File: rtl/rsq_cal_load.sv
module rsq_cal_load #(
    parameter int NUM_CAL = 3,
    parameter int CAL_CYC = 24,
    parameter int CAL_W   = 8,
    parameter int ADDR_W  = 4,
    parameter int CYC_W   = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          active_i,
    input  logic [CYC_W-1:0]              cyc_i,
    input  logic [CAL_W-1:0]              data_i,
    output logic                          rd_o,
    output logic [ADDR_W-1:0]             addr_o,
    output logic [NUM_CAL-1:0][CAL_W-1:0] cal_o
);
    localparam int               GAP   = CAL_CYC / NUM_CAL;
    localparam logic [CYC_W-1:0] GAP_V = CYC_W'(GAP);

    logic [CYC_W-1:0] slot;

    assign slot   = cyc_i / GAP_V;
    assign rd_o   = active_i && ((cyc_i % GAP_V) == '0) && (slot < CYC_W'(NUM_CAL));
    assign addr_o = ADDR_W'(slot);

    for (genvar i = 0; i < NUM_CAL; i++) begin : g_cal
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cal_o[i] <= '0;
            end else if (rd_o && (slot == CYC_W'(i))) begin
                cal_o[i] <= data_i;
            end
        end
    end

    // R8
    rd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_o |=> !rd_o);

    // R8
    rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_o |-> (addr_o < ADDR_W'(NUM_CAL)));
endmodule

// File: rtl/rst_release_seq.sv
module rst_release_seq
    import rsq_pkg::*;
#(
    parameter int NUM_REQ   = 5,
    parameter int DLY_LONG  = 64,
    parameter int DLY_SHORT = 4,
    parameter int OSC_CYC   = 6,
    parameter int CAL_CYC   = 24,
    parameter int CAL_W     = 8,
    parameter int ADDR_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req_i,
    input  logic               slow_tick_i,
    input  logic [1:0]         sut_sel_i,
    input  logic [CAL_W-1:0]   nvm_data_i,
    output logic               nvm_rd_o,
    output logic [ADDR_W-1:0]  nvm_addr_o,
    output logic [CAL_W-1:0]   cal_2m_o,
    output logic [CAL_W-1:0]   cal_32m_o,
    output logic [CAL_W-1:0]   cal_32k_o,
    output logic               rst_o,
    output logic [2:0]         stage_o,
    output logic               run_pulse_o
);
    localparam int NUM_CAL = 3;
    localparam int DLY_W   = $clog2(DLY_LONG + 1);
    localparam int CYC_MAX = (CAL_CYC > OSC_CYC) ? CAL_CYC : OSC_CYC;
    localparam int CYC_W   = $clog2(CYC_MAX);
    localparam logic [CYC_W-1:0] OSC_LAST = CYC_W'(OSC_CYC - 1);
    localparam logic [CYC_W-1:0] CAL_LAST = CYC_W'(CAL_CYC - 1);

    rsq_stage_e state, state_n;

    logic [NUM_REQ-1:0]          req_s;
    logic                        any_s;
    logic [DLY_W-1:0]            dly_sel;
    logic [DLY_W-1:0]            dly_tgt;
    logic [DLY_W-1:0]            dly_cnt;
    logic [CYC_W-1:0]            cyc_cnt;
    logic                        run_pulse_q;
    logic [NUM_CAL-1:0][CAL_W-1:0] cal_q;

    rsq_sync2 #(.WIDTH(NUM_REQ)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (req_i),
        .q_o   (req_s)
    );

    assign any_s = |req_s;

    rsq_dly_map #(
        .DLY_LONG  (DLY_LONG),
        .DLY_SHORT (DLY_SHORT),
        .DLY_W     (DLY_W)
    ) u_map (
        .sel_i   (sut_sel_i),
        .ticks_o (dly_sel)
    );

    rsq_cal_load #(
        .NUM_CAL (NUM_CAL),
        .CAL_CYC (CAL_CYC),
        .CAL_W   (CAL_W),
        .ADDR_W  (ADDR_W),
        .CYC_W   (CYC_W)
    ) u_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (state == ST_CAL),
        .cyc_i    (cyc_cnt),
        .data_i   (nvm_data_i),
        .rd_o     (nvm_rd_o),
        .addr_o   (nvm_addr_o),
        .cal_o    (cal_q)
    );

    // Next-state logic
    always_comb begin
        state_n = state;
        if (any_s) begin
            state_n = ST_RESET;
        end else begin
            unique case (state)
                ST_RESET: state_n = ST_DELAY;
                ST_DELAY: if (dly_cnt == dly_tgt) state_n = ST_OSC;
                ST_OSC:   if (cyc_cnt == OSC_LAST) state_n = ST_CAL;
                ST_CAL:   if (cyc_cnt == CAL_LAST) state_n = ST_RUN;
                ST_RUN:   state_n = ST_RUN;
                default:  state_n = ST_RESET;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= state_n;
    end

    // Stage counters and latched delay target
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_tgt <= '0;
            dly_cnt <= '0;
            cyc_cnt <= '0;
        end else begin
            if (state == ST_RESET && state_n == ST_DELAY) dly_tgt <= dly_sel;
            if (state_n != state) begin
                dly_cnt <= '0;
                cyc_cnt <= '0;
            end else begin
                if (state == ST_DELAY && slow_tick_i && dly_cnt != dly_tgt)
                    dly_cnt <= dly_cnt + 1'b1;
                if (state == ST_OSC || state == ST_CAL)
                    cyc_cnt <= cyc_cnt + 1'b1;
            end
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_pulse_q <= 1'b0;
        else        run_pulse_q <= (state_n == ST_RUN) && (state != ST_RUN);
    end

    always_comb begin
        rst_o       = (state != ST_RUN) || (|req_i);
        stage_o     = state;
        run_pulse_o = run_pulse_q;
        cal_2m_o    = cal_q[0];
        cal_32m_o   = cal_q[1];
        cal_32k_o   = cal_q[2];
    end

    // R2
    req_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_s |=> (state == ST_RESET));

    // R3
    run_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && $past(state) != ST_RUN) |-> ($past(state) == ST_CAL));

    // R3
    osc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OSC && $past(state) != ST_OSC) |-> ($past(state) == ST_DELAY));

    // R7
    osc_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAL && $past(state) == ST_OSC) |-> ($past(cyc_cnt) == OSC_LAST));

    // R6
    zero_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DELAY && dly_tgt == '0) |=> (state != ST_DELAY));

    // R10
    run_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_pulse_o |-> (state == ST_RUN && $past(state) != ST_RUN));
endmodule

// File: tb/rst_release_seq_tb_top.sv
module rst_release_seq_tb_top;
    localparam int NUM_REQ = 5;
    localparam int CAL_W   = 8;
    localparam int ADDR_W  = 4;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [NUM_REQ-1:0] req;
    logic               tick;
    logic [1:0]         sel;
    logic [CAL_W-1:0]   nvm_data;
    logic               nvm_rd;
    logic [ADDR_W-1:0]  nvm_addr;
    logic [CAL_W-1:0]   cal_2m, cal_32m, cal_32k;
    logic               rst_out;
    logic [2:0]         stage;
    logic               run_pulse;
    logic [7:0]         salt;

    int checks = 0;
    int errors = 0;
    int pos;
    int abort_at;
    bit hit;

    always #5 clk = ~clk;

    function automatic logic [7:0] mem_word(logic [7:0] s, logic [ADDR_W-1:0] a);
        return s ^ (8'(a) * 8'h35 + 8'h11);
    endfunction

    function automatic int exp_ticks(logic [1:0] s);
        case (s)
            2'b00:   return 64;
            2'b01:   return 4;
            2'b10:   return 64;
            default: return 0;
        endcase
    endfunction

    assign nvm_data = mem_word(salt, nvm_addr);

    rst_release_seq dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .slow_tick_i (tick),
        .sut_sel_i   (sel),
        .nvm_data_i  (nvm_data),
        .nvm_rd_o    (nvm_rd),
        .nvm_addr_o  (nvm_addr),
        .cal_2m_o    (cal_2m),
        .cal_32m_o   (cal_32m),
        .cal_32k_o   (cal_32k),
        .rst_o       (rst_out),
        .stage_o     (stage),
        .run_pulse_o (run_pulse)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_abort();
        int hold;
        tick = 1'b0;
        req  = NUM_REQ'(1 << ($urandom % NUM_REQ)) | NUM_REQ'($urandom);
        #1;
        chk("R1 rst_o same cycle as request", int'(rst_out), 1);
        repeat (3) @(negedge clk);
        chk("R2 RESET three edges after request", int'(stage), 0);
        hold = 1 + int'($urandom % 4);
        repeat (hold) begin
            @(negedge clk);
            chk("R2 stays RESET while held", int'(stage), 0);
            chk("R1 rst_o while held", int'(rst_out), 1);
        end
    endtask

    task automatic adv();
        @(negedge clk);
        pos++;
        if (pos == abort_at && !hit) begin
            hit = 1'b1;
            do_abort();
        end
    endtask

    task automatic run_chain(logic [1:0] s, int gap, int ab);
        int n;
        pos = 0; hit = 1'b0; abort_at = ab;
        sel = s; req = '0; tick = 1'b0; salt = 8'($urandom);
        n = exp_ticks(s);
        adv(); if (hit) return;
        chk("R3 RESET during sync", int'(stage), 0);
        adv(); if (hit) return;
        chk("R3 RESET during sync", int'(stage), 0);
        adv(); if (hit) return;
        chk("R3 DELAY at third edge", int'(stage), 1);
        for (int i = 0; i < n; i++) begin
            for (int g = 1; g < gap; g++) begin
                adv(); if (hit) return;
                chk("R5 DELAY between ticks", int'(stage), 1);
            end
            tick = 1'b1;
            adv(); tick = 1'b0; if (hit) return;
            chk("R5 DELAY until edge after last tick", int'(stage), 1);
        end
        adv(); if (hit) return;
        chk(n == 0 ? "R6 zero setting one cycle" : "R4 delay count", int'(stage), 2);
        for (int k = 0; k < 6; k++) begin
            chk("R7 OSC_START length", int'(stage), 2);
            tick = 1'($urandom);
            adv(); if (hit) return;
        end
        tick = 1'b0;
        for (int k = 0; k < 24; k++) begin
            chk("R8 CAL_LOAD length", int'(stage), 3);
            chk("R8 read strobe offset", int'(nvm_rd), (k % 8 == 0) ? 1 : 0);
            if (nvm_rd) chk("R8 read address", int'(nvm_addr), k / 8);
            chk("R1 rst_o before RUN", int'(rst_out), 1);
            tick = 1'($urandom);
            adv(); if (hit) return;
        end
        tick = 1'b0;
        chk("R3 RUN after CAL_LOAD", int'(stage), 4);
        chk("R10 rst_o low in RUN", int'(rst_out), 0);
        chk("R10 run pulse first cycle", int'(run_pulse), 1);
        chk("R9 cal 2 MHz word", int'(cal_2m), int'(mem_word(salt, 0)));
        chk("R9 cal 32 MHz word", int'(cal_32m), int'(mem_word(salt, 1)));
        chk("R9 cal 32 kHz word", int'(cal_32k), int'(mem_word(salt, 2)));
        adv(); if (hit) return;
        chk("R10 run pulse single cycle", int'(run_pulse), 0);
        chk("R10 stays RUN", int'(stage), 4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; req = NUM_REQ'(1); tick = 1'b0; sel = 2'b00; salt = 8'h00;
        repeat (3) @(negedge clk);
        chk("R3 reset state stage", int'(stage), 0);
        chk("R1 reset state rst_o", int'(rst_out), 1);
        chk("R10 reset state pulse", int'(run_pulse), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 held request keeps RESET", int'(stage), 0);

        // R5: ticks in RESET must not count
        repeat (6) begin
            tick = 1'b1; @(negedge clk); tick = 1'b0;
            chk("R5 tick ignored in RESET", int'(stage), 0);
        end
        run_chain(2'b01, 1, -1); if (!hit) do_abort();
        run_chain(2'b11, 1, -1); if (!hit) do_abort();
        run_chain(2'b00, 2, -1); if (!hit) do_abort();
        run_chain(2'b10, 1, -1); if (!hit) do_abort();   // R4 reserved code
        // R11: abort in the middle of DELAY, then a full count again
        run_chain(2'b01, 3, 6);
        run_chain(2'b01, 3, -1); if (!hit) do_abort();

        for (int it = 0; it < 30; it++) begin
            logic [1:0] s;
            int gap, ab;
            s   = 2'($urandom);
            gap = 1 + int'($urandom % 4);
            ab  = ($urandom % 3 == 0) ? 1 + int'($urandom % 40) : -1;
            run_chain(s, gap, ab);
            if (!hit) do_abort();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule